// File: doc/BRIEF.md
# DRAM Command/Address Decoder

This block watches the command and address pins of a fourth-generation DDR memory device and turns each clock's pin state into a typed command with its fields split out. A downstream model or monitor can then act on a clean record: a valid strobe, a command kind, row, column, bank group and bank, an auto-precharge flag, a burst-chop flag and a flag for accesses that go to the multi-purpose register instead of the array.

Three upper address pins have two meanings. When the activate pin is low they are the top row bits. When it is high they are the row-strobe, column-strobe and write-enable opcode. During reads and writes, address bit 10 requests auto-precharge and bit 12 can pick the burst length. A small shadow of two mode-register fields sets how bit 12 is treated and whether reads and writes go to the multi-purpose register. That shadow is loaded through a separate configuration write port.

The decoder has no sequential control flow of its own. It classifies the pins in a combinational stage and then registers the result once. The command kinds are: deselect (0), no-op (1), activate (2), read (3), write (4), precharge (5), refresh (6) and mode-register set (7).

Top module: `dram_cmd_decoder`

## Requirements
- R1: When cke is low at a clock edge, cmd_vld is 0 after that edge and every other output keeps its previous value.
- R2: When cke is high and cs_n is high, the result is cmd_vld=1 and kind deselect (0), with row, col, bg, ba and all flags zero, whatever the other pins carry.
- R3: When cke is high and both cs_n and act_n are low, the kind is activate (2). row takes addr[16:0], and bg and ba take bg_in and ba_in. col and all flags are zero.
- R4: When cke is high, cs_n is low and act_n is high, the opcode {addr[16],addr[15],addr[14]} selects the kind: 100 write (4), 101 read (3), 010 precharge (5), 001 refresh (6), 000 mode-register set (7), 111 no-op (1). The unassigned codes 110 and 011 also decode as no-op.
- R5: For reads and writes, col takes addr[9:0], bg and ba take bg_in and ba_in, and row is zero.
- R6: For reads and writes, auto_pre equals addr[10]. For every other kind it is 0.
- R7: For reads and writes, burst_chop depends on the burst field (mode index 0, cfg_val[1:0]). With field 01 (on the fly), burst_chop equals addr[12]. With field 10 (fixed chop-4), it is 1. With 00 or 11 (fixed length 8), it is 0. For every other kind it is 0.
- R8: For reads and writes, mpr_hit equals the multi-purpose enable (mode index 3, cfg_val[2]). For every other kind it is 0.
- R9: A configuration write (cfg_we=1) updates the shadow at that edge. A command sampled at the same edge still uses the old setting; later commands use the new one. Writes to any index other than 0 and 3 change nothing.
- R10: Outputs reflect the pins sampled at one clock edge, available right after that edge. After reset all outputs are zero, the burst field is 00 and the multi-purpose enable is 0.
- R11: Precharge carries bg and ba with all other fields zero. Refresh and no-op carry all fields zero. Mode-register set carries bg and ba, and row[13:0] = addr[13:0] with row[16:14] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable; pins sampled only when high |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate select, active low |
| addr | input | 17 | Address bus A16..A0 |
| bg_in | input | 2 | Bank group pins |
| ba_in | input | 2 | Bank address pins |
| cfg_we | input | 1 | Mode shadow write enable |
| cfg_idx | input | 3 | Mode register index for the write |
| cfg_val | input | 3 | Write value: [1:0] burst field, [2] multi-purpose enable |
| cmd_vld | output | 1 | A command was sampled at the last edge |
| cmd_type | output | 3 | Command kind code |
| row | output | 17 | Row address or mode-register opcode |
| col | output | 10 | Column address |
| bg | output | 2 | Bank group |
| ba | output | 2 | Bank |
| auto_pre | output | 1 | Auto-precharge requested |
| burst_chop | output | 1 | 1 = chop-4, 0 = length 8 |
| mpr_hit | output | 1 | Access diverted to the multi-purpose register |

## Verification
Every decoded result appears exactly one clock edge after the pins that produced it. The bench drives pins on a falling edge, lets one rising edge capture them, and compares all outputs at the next falling edge. A configuration write takes effect for commands one edge later, so the bench's mode model computes the expected value from the old setting before applying the write. When cke is low, the expected record is the previous one with the strobe cleared. This checks the one-cycle hold as well as the decode.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        CMD_DES = 3'd0,
        CMD_NOP = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_PRE = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BL_FIX8 = 2'd0,
        BL_OTF  = 2'd1,
        BL_FIX4 = 2'd2,
        BL_RSV  = 2'd3
    } blmode_e;

    // opcode on {addr[16],addr[15],addr[14]} while act_n is high
    localparam logic [2:0] OP_MRS = 3'b000;
    localparam logic [2:0] OP_REF = 3'b001;
    localparam logic [2:0] OP_PRE = 3'b010;
    localparam logic [2:0] OP_RSV = 3'b011;
    localparam logic [2:0] OP_WR  = 3'b100;
    localparam logic [2:0] OP_RD  = 3'b101;
    localparam logic [2:0] OP_ZQ  = 3'b110;
    localparam logic [2:0] OP_NOP = 3'b111;

    localparam int OP_HI   = 16;
    localparam int OP_LO   = 14;
    localparam int AP_BIT  = 10;
    localparam int BC_BIT  = 12;
    localparam int MRS_OPW = 14;

    localparam logic [2:0] IDX_BURST = 3'd0;
    localparam logic [2:0] IDX_MPR   = 3'd3;

endpackage

// File: rtl/dcd_mode_regs.sv
module dcd_mode_regs
    import dcd_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int CFG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0] cfg_val,
    output blmode_e          bl_mode,
    output logic             mpr_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bl_mode <= BL_FIX8;
            mpr_en  <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_idx == IDX_BURST) bl_mode <= blmode_e'(cfg_val[1:0]);
            if (cfg_idx == IDX_MPR)   mpr_en  <= cfg_val[2];
        end
    end

    // R9: write to the multi-purpose index lands on the next edge
    p_mpr_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx == IDX_MPR) |=> (mpr_en == $past(cfg_val[2])));

    // R9: writes elsewhere leave the shadow untouched
    p_other_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || (cfg_idx != IDX_MPR && cfg_idx != IDX_BURST))
        |=> ($stable(mpr_en) && $stable(bl_mode)));

endmodule

// File: rtl/dcd_classify.sv
module dcd_classify
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BA_W   = 2
) (
    input  logic              cs_n,
    input  logic              act_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BG_W-1:0]   bg_in,
    input  logic [BA_W-1:0]   ba_in,
    input  blmode_e           bl_mode,
    input  logic              mpr_en,
    output cmd_e              kind,
    output logic [ADDR_W-1:0] row,
    output logic [COL_W-1:0]  col,
    output logic [BG_W-1:0]   bg,
    output logic [BA_W-1:0]   ba,
    output logic              auto_pre,
    output logic              burst_chop,
    output logic              mpr_hit
);

    logic [2:0] opcode;
    logic       chop_sel;

    assign opcode = addr[OP_HI:OP_LO];

    always_comb begin
        unique case (bl_mode)
            BL_OTF:  chop_sel = addr[BC_BIT];
            BL_FIX4: chop_sel = 1'b1;
            default: chop_sel = 1'b0;
        endcase
    end

    always_comb begin
        kind       = CMD_NOP;
        row        = '0;
        col        = '0;
        bg         = '0;
        ba         = '0;
        auto_pre   = 1'b0;
        burst_chop = 1'b0;
        mpr_hit    = 1'b0;
        if (cs_n) begin
            kind = CMD_DES;
        end else if (!act_n) begin
            kind = CMD_ACT;
            row  = addr;
            bg   = bg_in;
            ba   = ba_in;
        end else begin
            unique case (opcode)
                OP_WR, OP_RD: begin
                    kind       = (opcode == OP_WR) ? CMD_WR : CMD_RD;
                    col        = addr[COL_W-1:0];
                    bg         = bg_in;
                    ba         = ba_in;
                    auto_pre   = addr[AP_BIT];
                    burst_chop = chop_sel;
                    mpr_hit    = mpr_en;
                end
                OP_PRE: begin
                    kind = CMD_PRE;
                    bg   = bg_in;
                    ba   = ba_in;
                end
                OP_REF: kind = CMD_REF;
                OP_MRS: begin
                    kind               = CMD_MRS;
                    bg                 = bg_in;
                    ba                 = ba_in;
                    row[MRS_OPW-1:0]   = addr[MRS_OPW-1:0];
                end
                OP_NOP, OP_ZQ, OP_RSV: kind = CMD_NOP;
                default: kind = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BA_W   = 2,
    parameter int IDX_W  = 3,
    parameter int CFG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              act_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BG_W-1:0]   bg_in,
    input  logic [BA_W-1:0]   ba_in,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_val,
    output logic              cmd_vld,
    output logic [2:0]        cmd_type,
    output logic [ADDR_W-1:0] row,
    output logic [COL_W-1:0]  col,
    output logic [BG_W-1:0]   bg,
    output logic [BA_W-1:0]   ba,
    output logic              auto_pre,
    output logic              burst_chop,
    output logic              mpr_hit
);

    blmode_e           bl_mode;
    logic              mpr_en;
    cmd_e              d_kind;
    logic [ADDR_W-1:0] d_row;
    logic [COL_W-1:0]  d_col;
    logic [BG_W-1:0]   d_bg;
    logic [BA_W-1:0]   d_ba;
    logic              d_ap;
    logic              d_bc;
    logic              d_mpr;

    dcd_mode_regs #(.IDX_W(IDX_W), .CFG_W(CFG_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_idx (cfg_idx),
        .cfg_val (cfg_val),
        .bl_mode (bl_mode),
        .mpr_en  (mpr_en)
    );

    dcd_classify #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W)) u_cls (
        .cs_n       (cs_n),
        .act_n      (act_n),
        .addr       (addr),
        .bg_in      (bg_in),
        .ba_in      (ba_in),
        .bl_mode    (bl_mode),
        .mpr_en     (mpr_en),
        .kind       (d_kind),
        .row        (d_row),
        .col        (d_col),
        .bg         (d_bg),
        .ba         (d_ba),
        .auto_pre   (d_ap),
        .burst_chop (d_bc),
        .mpr_hit    (d_mpr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_vld    <= 1'b0;
            cmd_type   <= 3'd0;
            row        <= '0;
            col        <= '0;
            bg         <= '0;
            ba         <= '0;
            auto_pre   <= 1'b0;
            burst_chop <= 1'b0;
            mpr_hit    <= 1'b0;
        end else if (cke) begin
            cmd_vld    <= 1'b1;
            cmd_type   <= d_kind;
            row        <= d_row;
            col        <= d_col;
            bg         <= d_bg;
            ba         <= d_ba;
            auto_pre   <= d_ap;
            burst_chop <= d_bc;
            mpr_hit    <= d_mpr;
        end else begin
            cmd_vld    <= 1'b0;
        end
    end

    // R1: no sampling while clock enable is low
    p_cke_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> (!cmd_vld && $stable(cmd_type) && $stable(row) && $stable(col)));

    // R2: deselect masks every other pin
    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && cs_n) |=> (cmd_vld && cmd_type == 3'd0 && row == '0 && col == '0
                           && !auto_pre && !burst_chop && !mpr_hit));

    // R3: activate takes the full bus as row
    p_act_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !act_n) |=> (cmd_type == 3'd2 && row == $past(addr)
                                      && bg == $past(bg_in) && ba == $past(ba_in)));

    // R5 / R6: read column and auto-precharge follow the pins
    p_read_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && act_n && addr[OP_HI:OP_LO] == OP_RD)
        |=> (cmd_type == 3'd3 && col == $past(addr[COL_W-1:0])
             && auto_pre == $past(addr[AP_BIT]) && row == '0));

    // R6 / R7 / R8: flags only on column commands
    p_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_type != 3'd3 && cmd_type != 3'd4) |-> (!auto_pre && !burst_chop && !mpr_hit));

endmodule

// File: tb/dram_cmd_decoder_tb.sv
module dram_cmd_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0;
    logic        cs_n = 1'b1;
    logic        act_n = 1'b1;
    logic [16:0] addr = '0;
    logic [1:0]  bg_in = '0;
    logic [1:0]  ba_in = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [2:0]  cfg_val = '0;
    logic        cmd_vld;
    logic [2:0]  cmd_type;
    logic [16:0] row;
    logic [9:0]  col;
    logic [1:0]  bg;
    logic [1:0]  ba;
    logic        auto_pre;
    logic        burst_chop;
    logic        mpr_hit;

    int checks = 0;
    int errors = 0;

    logic [1:0]  m_bl = 2'd0;
    logic        m_mpr = 1'b0;
    logic [37:0] prev_exp = '0;

    always #5 clk = ~clk;

    dram_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .act_n(act_n),
        .addr(addr), .bg_in(bg_in), .ba_in(ba_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val),
        .cmd_vld(cmd_vld), .cmd_type(cmd_type), .row(row), .col(col),
        .bg(bg), .ba(ba), .auto_pre(auto_pre), .burst_chop(burst_chop),
        .mpr_hit(mpr_hit)
    );

    function automatic logic [37:0] model(input logic k, input logic cs, input logic ac,
                                          input logic [16:0] a, input logic [1:0] g,
                                          input logic [1:0] b, input logic [1:0] bl,
                                          input logic mp, input logic [37:0] prev);
        logic [2:0]  t = 3'd1;
        logic [16:0] r = '0;
        logic [9:0]  c = '0;
        logic [1:0]  og = '0;
        logic [1:0]  ob = '0;
        logic        ap = 1'b0;
        logic        bc = 1'b0;
        logic        mh = 1'b0;
        if (!k) begin
            model = prev;
            model[37] = 1'b0;
            return model;
        end
        if (cs) begin
            t = 3'd0;
        end else if (!ac) begin
            t = 3'd2; r = a; og = g; ob = b;
        end else begin
            case (a[16:14])
                3'b100, 3'b101: begin
                    t  = (a[16:14] == 3'b100) ? 3'd4 : 3'd3;
                    c  = a[9:0]; og = g; ob = b; ap = a[10];
                    bc = (bl == 2'd1) ? a[12] : (bl == 2'd2);
                    mh = mp;
                end
                3'b010: begin t = 3'd5; og = g; ob = b; end
                3'b001: t = 3'd6;
                3'b000: begin t = 3'd7; og = g; ob = b; r[13:0] = a[13:0]; end
                default: t = 3'd1;
            endcase
        end
        return {1'b1, t, r, c, og, ob, ap, bc, mh};
    endfunction

    task automatic cyc(input string tag, input logic k, input logic cs, input logic ac,
                       input logic [16:0] a, input logic [1:0] g, input logic [1:0] b,
                       input logic we, input logic [2:0] idx, input logic [2:0] val);
        logic [37:0] exp_v;
        logic [37:0] act_v;
        cke = k; cs_n = cs; act_n = ac; addr = a; bg_in = g; ba_in = b;
        cfg_we = we; cfg_idx = idx; cfg_val = val;
        exp_v = model(k, cs, ac, a, g, b, m_bl, m_mpr, prev_exp);
        prev_exp = exp_v;
        if (we && idx == 3'd0) m_bl = val[1:0];
        if (we && idx == 3'd3) m_mpr = val[2];
        @(negedge clk);
        act_v = {cmd_vld, cmd_type, row, col, bg, ba, auto_pre, burst_chop, mpr_hit};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [2:0] val);
        cyc("R9", 1'b1, 1'b1, 1'b1, 17'h1ffff, 2'd3, 2'd3, 1'b1, idx, val);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        checks++;
        if ({cmd_vld, cmd_type, row, col, auto_pre, burst_chop, mpr_hit} !== '0) begin
            errors++;
            $display("FAIL R10 reset actual=%b expected=0", cmd_vld);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // every opcode with act_n high, then act_n low
        cyc("R4", 1, 0, 1, {3'b100, 14'h0412}, 2'd1, 2'd2, 0, 0, 0);
        cyc("R4", 1, 0, 1, {3'b101, 14'h07ff}, 2'd2, 2'd1, 0, 0, 0);
        cyc("R11", 1, 0, 1, {3'b010, 14'h3fff}, 2'd3, 2'd0, 0, 0, 0);
        cyc("R11", 1, 0, 1, {3'b001, 14'h3fff}, 2'd3, 2'd3, 0, 0, 0);
        cyc("R11", 1, 0, 1, {3'b000, 14'h2a55}, 2'd1, 2'd1, 0, 0, 0);
        cyc("R4", 1, 0, 1, {3'b111, 14'h3fff}, 2'd3, 2'd3, 0, 0, 0);
        cyc("R4", 1, 0, 1, {3'b110, 14'h3fff}, 2'd3, 2'd3, 0, 0, 0);
        cyc("R4", 1, 0, 1, {3'b011, 14'h3fff}, 2'd3, 2'd3, 0, 0, 0);
        cyc("R3", 1, 0, 0, 17'h1abcd, 2'd2, 2'd3, 0, 0, 0);
        cyc("R3", 1, 0, 0, 17'h1ffff, 2'd3, 2'd3, 0, 0, 0);
        cyc("R2", 1, 1, 0, 17'h1ffff, 2'd3, 2'd3, 0, 0, 0);
        // clock enable low holds the last record
        cyc("R3", 1, 0, 0, 17'h15555, 2'd1, 2'd0, 0, 0, 0);
        cyc("R1", 0, 0, 1, {3'b101, 14'h0001}, 2'd0, 2'd0, 0, 0, 0);
        cyc("R1", 0, 1, 1, 17'h0, 2'd0, 2'd0, 0, 0, 0);
        // auto-precharge on both column commands
        cyc("R6", 1, 0, 1, {3'b101, 14'h0400}, 2'd0, 2'd0, 0, 0, 0);
        cyc("R6", 1, 0, 1, {3'b100, 14'h0000}, 2'd0, 2'd0, 0, 0, 0);
        // burst modes: same-edge write uses old setting
        cyc("R9", 1, 0, 1, {3'b101, 14'h1000}, 2'd0, 2'd0, 1, 3'd0, 3'b001);
        cyc("R7", 1, 0, 1, {3'b101, 14'h1000}, 2'd0, 2'd0, 0, 0, 0);
        cyc("R7", 1, 0, 1, {3'b100, 14'h0000}, 2'd0, 2'd0, 0, 0, 0);
        cfg(3'd0, 3'b010);
        cyc("R7", 1, 0, 1, {3'b100, 14'h0000}, 2'd0, 2'd0, 0, 0, 0);
        cfg(3'd0, 3'b011);
        cyc("R7", 1, 0, 1, {3'b101, 14'h1000}, 2'd0, 2'd0, 0, 0, 0);
        // multi-purpose mode on and off, ignored index
        cfg(3'd3, 3'b100);
        cyc("R8", 1, 0, 1, {3'b101, 14'h0003}, 2'd1, 2'd1, 0, 0, 0);
        cyc("R8", 1, 0, 1, {3'b100, 14'h0003}, 2'd1, 2'd1, 0, 0, 0);
        cyc("R8", 1, 0, 0, 17'h0003, 2'd1, 2'd1, 0, 0, 0);
        cfg(3'd5, 3'b000);
        cyc("R9", 1, 0, 1, {3'b101, 14'h0003}, 2'd1, 2'd1, 0, 0, 0);
        cfg(3'd3, 3'b000);
        cyc("R8", 1, 0, 1, {3'b101, 14'h0003}, 2'd1, 2'd1, 0, 0, 0);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic k  = ($urandom % 10) != 0;
            logic cs = ($urandom % 8) == 0;
            logic ac = ($urandom % 4) != 0;
            logic [16:0] a = 17'($urandom);
            logic we = ($urandom % 8) == 0;
            string tag;
            if (!k) tag = "R1";
            else if (cs) tag = "R2";
            else if (!ac) tag = "R3";
            else tag = "R5";
            cyc(tag, k, cs, ac, a, 2'($urandom), 2'($urandom), we,
                3'($urandom), 3'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule